// File: doc/BRIEF.md
# Ping-Pong Capture DMA Channel

This block carries converter results into memory, one 16-bit word per result-ready trigger. It writes into a buffer that starts at a programmed base address and steps the write address by two bytes after every word. When the programmed number of words has been written, the channel raises a completion interrupt and disarms itself. It also flips an indicator that tells software which of the two buffers has just been filled.

Software keeps two buffers and alternates between them. After each completion it loads the base address of the other buffer and re-arms the channel before the next result arrives. The channel responds only to trigger edges. A trigger edge that arrives while the channel is disarmed is dropped, as is one that arrives while a word is still in flight. In either case no write takes place and a sticky missed-trigger flag is set, so software can detect the stall.

Top module: `pingpong_capture_dma`

## Requirements
- R1: After reset the channel is disarmed, `irq`, `miss_flag`, `active_buf` and `mem_we` are all 0.
- R2: A pulse on `arm` while no word is in flight loads the write address from the base register and the remaining count from the count register, sets `armed` and clears `irq`; an arm with a programmed count of 0 is ignored.
- R3: A rising edge of `trig` while armed and idle produces exactly one memory write whose data is the low 12 bits of `src_data` (sampled at the edge) zero-extended to 16 bits; `mem_we` is high for one cycle, the write completing on the fourth clock edge counting the one that samples the trigger edge.
- R4: After each write the write address increases by 2.
- R5: When the number of writes since arming reaches the programmed count, `armed` clears and `irq` rises on the same edge that completes the last write, and `irq` stays high until the next accepted arm.
- R6: `active_buf` toggles each time a block completes.
- R7: A trigger edge while disarmed causes no write and sets `miss_flag`.
- R8: A trigger edge while a word is in flight is not queued: only the in-flight word is written, and `miss_flag` is set.
- R9: `miss_flag` stays set until a `miss_clr` pulse; when a new miss and a clear coincide, the flag stays set.
- R10: Holding `trig` high produces a single transfer; only the rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Result-ready trigger, rising edge acts |
| src_data | input | 16 | Converter result, low 12 bits used |
| base_we | input | 1 | Load strobe for base address register |
| base_in | input | 16 | Buffer base byte address |
| count_we | input | 1 | Load strobe for count register |
| count_in | input | 16 | Words per block (1 to 65535) |
| arm | input | 1 | Arm pulse: reload address and count |
| miss_clr | input | 1 | Clear pulse for the missed-trigger flag |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write byte address |
| mem_wdata | output | 16 | Memory write data |
| irq | output | 1 | Block-complete interrupt (level) |
| armed | output | 1 | Channel is armed |
| active_buf | output | 1 | Toggles on each completed block |
| miss_flag | output | 1 | Sticky missed-trigger flag |

## Verification
Inputs change on the falling clock edge, and the rising edge that follows samples the trigger edge. `mem_we`, `mem_addr` and `mem_wdata` are checked three clock edges later, while the strobe is high. The address step, the count, `irq`, `armed`, `active_buf` and `miss_flag` are checked after the fourth edge, once the write has completed. Every sample is taken on a falling edge. Each stimulus waits out the full four-cycle transfer before the next one starts, except the deliberate overlap case, which raises a second trigger edge on the third cycle of a transfer.

// File: rtl/pingpong_capture_dma.sv
module pingpong_capture_dma #(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int RES_W    = 12,
  parameter int XFER_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [15:0]       src_data,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              count_we,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              arm,
  input  logic              miss_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              irq,
  output logic              armed,
  output logic              active_buf,
  output logic              miss_flag
);
  localparam int PH_W = (XFER_CYC > 2) ? $clog2(XFER_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(XFER_CYC - 1);
  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(2);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] base_q, addr_q;
  logic [CNT_W-1:0]  count_q, rem_q;
  logic [15:0]       data_q;
  logic [PH_W-1:0]   phase_q;
  logic              trig_q, armed_q, irq_q, buf_q, miss_q;

  logic trig_rise, busy, start, lost, finish, last_word, arm_ok;

  assign trig_rise = trig & ~trig_q;
  assign busy      = phase_q != '0;
  assign start     = trig_rise & armed_q & ~busy;
  assign lost      = trig_rise & (~armed_q | busy);
  assign finish    = phase_q == PH_LAST;
  assign last_word = finish && (rem_q == CNT_ONE);
  assign arm_ok    = arm & ~busy & (count_q != '0);

  assign mem_we     = finish;
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;
  assign irq        = irq_q;
  assign armed      = armed_q;
  assign active_buf = buf_q;
  assign miss_flag  = miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      count_q <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= trig;
      if (base_we)  base_q  <= base_in;
      if (count_we) count_q <= count_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      data_q  <= '0;
    end else begin
      if (start) begin
        phase_q <= PH_ONE;
        data_q  <= {{(16-RES_W){1'b0}}, src_data[RES_W-1:0]};
      end else if (busy) begin
        phase_q <= finish ? '0 : phase_q + PH_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rem_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      buf_q   <= 1'b0;
    end else begin
      if (arm_ok) begin
        addr_q  <= base_q;
        rem_q   <= count_q;
        armed_q <= 1'b1;
        irq_q   <= 1'b0;
      end else if (finish) begin
        addr_q <= addr_q + STEP;
        rem_q  <= rem_q - CNT_ONE;
        if (last_word) begin
          armed_q <= 1'b0;
          irq_q   <= 1'b1;
          buf_q   <= ~buf_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        miss_q <= 1'b0;
    else if (lost)     miss_q <= 1'b1;
    else if (miss_clr) miss_q <= 1'b0;
  end

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !last_word) |=> (mem_addr == $past(mem_addr) + STEP));

  // R5
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> (irq && !armed));

  // R6
  buf_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (active_buf != $past(active_buf)));

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R7
  miss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !trig_q && !armed) |=> miss_flag);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(mem_wdata));
endmodule

// File: tb/tb_pingpong_capture_dma.sv
module tb_pingpong_capture_dma;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, trig = 0, base_we = 0, count_we = 0, arm = 0, miss_clr = 0;
  logic [15:0] src_data = 0, base_in = 0, count_in = 0;
  logic mem_we, irq, armed, active_buf, miss_flag;
  logic [15:0] mem_addr, mem_wdata;

  pingpong_capture_dma dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .src_data(src_data),
    .base_we(base_we), .base_in(base_in), .count_we(count_we), .count_in(count_in),
    .arm(arm), .miss_clr(miss_clr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq), .armed(armed), .active_buf(active_buf),
    .miss_flag(miss_flag));

  always #(CLK_P/2) clk = ~clk;

  int tests = 0, fails = 0, wr_cnt = 0;
  bit finished = 0;
  logic [15:0] e_addr = 0, e_rem = 0;
  logic e_armed = 0, e_irq = 0, e_buf = 0, e_miss = 0;

  always @(posedge clk) if (rst_n && mem_we) wr_cnt++;

  function automatic logic [15:0] res_of(input logic [15:0] d);
    return {4'h0, d[11:0]};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic chk_state(input string req);
    chk(req, "armed", armed, e_armed);
    chk(req, "irq", irq, e_irq);
    chk(req, "active_buf", active_buf, e_buf);
    chk(req, "miss_flag", miss_flag, e_miss);
    chk(req, "mem_addr", mem_addr, e_addr);
  endtask

  task automatic do_arm(input logic [15:0] base, input logic [15:0] cnt);
    base_in = base; base_we = 1; tick(); base_we = 0;
    count_in = cnt; count_we = 1; tick(); count_we = 0;
    arm = 1; tick(); arm = 0;
    if (cnt != 0) begin
      e_addr = base; e_rem = cnt; e_armed = 1; e_irq = 0;
    end
    chk("R2", "arm", armed, e_armed);
    chk("R2", "addr after arm", mem_addr, e_addr);
    chk("R2", "irq after arm", irq, e_irq);
  endtask

  task automatic do_trig(input logic [15:0] d);
    int w0;
    bit go;
    go = e_armed;
    w0 = wr_cnt;
    src_data = d; trig = 1;
    tick(); src_data = $urandom;
    tick(); tick();
    chk("R3", "mem_we", mem_we, go);
    if (go) begin
      chk("R3", "mem_wdata", mem_wdata, res_of(d));
      chk("R4", "mem_addr at write", mem_addr, e_addr);
    end
    trig = 0;
    tick();
    if (go) begin
      e_addr = e_addr + 2; e_rem--;
      if (e_rem == 0) begin e_armed = 0; e_irq = 1; e_buf = ~e_buf; end
    end else e_miss = 1;
    chk(go ? "R10" : "R7", "writes", wr_cnt - w0, go ? 1 : 0);
    chk_state(go ? "R5" : "R7");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    tick(); tick(); rst_n = 1; tick();
    chk("R1", "mem_we", mem_we, 0);
    chk_state("R1");

    // R7: trigger while disarmed
    do_trig(16'hABCD);
    // R9: clear
    miss_clr = 1; tick(); miss_clr = 0; e_miss = 0;
    chk("R9", "miss cleared", miss_flag, 0);

    // R2: count zero ignored
    do_arm(16'h0100, 16'd0);
    chk("R2", "count0 not armed", armed, 0);

    // Random ping-pong blocks
    for (int b = 0; b < 8; b++) begin
      logic [15:0] base;
      int n;
      base = (b % 2) ? 16'h4000 : 16'h2000;
      base = base + 16'(($urandom % 64) * 2);
      n = 1 + ($urandom % 7);
      do_arm(base, 16'(n));
      for (int i = 0; i < n; i++) do_trig(16'($urandom));
      chk("R5", "irq at done", irq, 1);
      chk("R6", "buf toggled", active_buf, b % 2 == 0);
      repeat ($urandom % 3) tick();
      chk("R5", "irq held", irq, 1);
    end

    // R7: trigger after completion is missed
    do_trig(16'h1234);
    chk("R7", "miss after done", miss_flag, 1);

    // R9: set wins over clear
    trig = 1; miss_clr = 1; tick(); miss_clr = 0; trig = 0; tick();
    chk("R9", "set beats clear", miss_flag, 1);
    miss_clr = 1; tick(); miss_clr = 0; e_miss = 0;
    chk("R9", "clear", miss_flag, 0);

    // R8: overlap
    do_arm(16'h6000, 16'd3);
    begin
      int w0;
      w0 = wr_cnt;
      src_data = 16'hF5A5; trig = 1; tick();
      trig = 0; tick();
      src_data = 16'h0777; trig = 1; tick();
      chk("R8", "in-flight data", mem_wdata, 16'h05A5);
      chk("R8", "mem_we", mem_we, 1);
      trig = 0; tick();
      repeat (5) tick();
      e_addr = e_addr + 2; e_rem--; e_miss = 1;
      chk("R8", "writes", wr_cnt - w0, 1);
      chk_state("R8");
    end
    do_trig(16'h0FFF);
    do_trig(16'hFFFF);
    chk("R5", "overlap block done", irq, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule